// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Half-Word Writes

This block is a register-mapped general-purpose I/O controller. It serves four banks of 32 pins through a 32-bit register bus. Each bank has an output value register, a direction register and an output-enable register. It also has a read-only view of the pad inputs, taken after a two-flop synchronizer. Not every bank position is a real pin. Bank 1 carries only its low 22 bits, so pins 54 to 63 do not exist. Storage, outputs and read-back at those positions are held at zero.

Software can change any subset of one 16-bit half of a bank's output value in a single write, with no read-modify-write. Each bank has two such ports, one for pins 0 to 15 and one for pins 16 to 31. In both ports the upper 16 bits of the write word are an active-low mask and the lower 16 bits are the new values. A pin drives its pad only when its direction bit and its enable bit are both 1. Reads are combinational from the address, and writes take effect at the next clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While reset is low, and right after it, every output value, direction and enable register reads 0, and `pin_out` and `pin_oe` are all 0.
- R2: A write to 0x40 + 4*bank replaces the bank's output value in the next cycle. Reading that address returns it, and `pin_out` shows it.
- R3: A write to 8*bank changes bits 15:0 of the bank's output value. Bit i takes wr_data[i] where wr_data[16+i] is 0 and keeps its old value where wr_data[16+i] is 1. Bits 31:16 are unchanged.
- R4: A write to 8*bank + 4 works the same way on bits 31:16 of the bank's output value: bit 16+i is updated from wr_data[i] under mask bit wr_data[16+i]. Bits 15:0 are unchanged.
- R5: Direction is at 0x204 + 0x40*bank (1 = output) and enable is at 0x208 + 0x40*bank (1 = drive). A pin's `pin_oe` is 1 only when both bits are 1. An input pin never drives, and an output pin with enable 0 is tristated.
- R6: A read of 0x60 + 4*bank returns the bank's `pin_in` bits as they were two rising edges earlier.
- R7: Bits of bank 1 above bit 21 read 0 from every register, ignore writes, and hold `pin_out` and `pin_oe` at 0.
- R8: Reads of the masked-write addresses (0x00 to 0x1F) and of addresses that map no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Byte address for both read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| pin_out | output | NUM_BANKS*32 | Output value of each pin |
| pin_oe | output | NUM_BANKS*32 | Drive enable of each pin |
| pin_in | input | NUM_BANKS*32 | Pad input of each pin |

## Verification
The assertions take for granted three things about the inputs:
- `addr` is stable for the whole cycle in which it is sampled.
- At most one register is written per cycle.
- The input-sample check starts only after the synchronizer has seen two edges out of reset.

The bench keeps to these rules:
- It changes `addr`, `wr_en`, `wr_data` and `pin_in` only on falling edges.
- It issues one write at a time and lowers the strobe before reading back.
- It runs the synchronizer check only well after reset has been released.

Random writes are drawn across all five writable register kinds and all banks. Mask words are random, so partial, empty and full masks all occur.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 12,
  parameter logic [NUM_BANKS*32-1:0] PIN_PRESENT =
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wr_data,
  output logic [31:0]             rd_data,
  output logic [NUM_BANKS*32-1:0] pin_out,
  output logic [NUM_BANKS*32-1:0] pin_oe,
  input  logic [NUM_BANKS*32-1:0] pin_in
);
  localparam int NP = NUM_BANKS * 32;

  logic [NP-1:0] rd_part;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [31:0] PRES = PIN_PRESENT[b*32 +: 32];
    localparam logic [ADDR_W-1:0] A_MLO  = ADDR_W'(8 * b);
    localparam logic [ADDR_W-1:0] A_MHI  = ADDR_W'(8 * b + 4);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(64 + 4 * b);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(96 + 4 * b);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(516 + 64 * b);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(520 + 64 * b);

    logic [31:0] data_r, dir_r, oe_r, sync1_r, sync2_r, data_nxt;

    wire sel_mlo  = wr_en && (addr == A_MLO);
    wire sel_mhi  = wr_en && (addr == A_MHI);
    wire sel_data = wr_en && (addr == A_DATA);
    wire sel_dir  = wr_en && (addr == A_DIR);
    wire sel_oe   = wr_en && (addr == A_OE);

    always_comb begin
      data_nxt = data_r;
      if (sel_data)
        data_nxt = wr_data;
      else if (sel_mlo)
        data_nxt[15:0] = (data_r[15:0] & wr_data[31:16]) | (wr_data[15:0] & ~wr_data[31:16]);
      else if (sel_mhi)
        data_nxt[31:16] = (data_r[31:16] & wr_data[31:16]) | (wr_data[15:0] & ~wr_data[31:16]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_r  <= '0;
        dir_r   <= '0;
        oe_r    <= '0;
        sync1_r <= '0;
        sync2_r <= '0;
      end else begin
        data_r  <= data_nxt & PRES;
        if (sel_dir) dir_r <= wr_data & PRES;
        if (sel_oe)  oe_r  <= wr_data & PRES;
        sync1_r <= pin_in[b*32 +: 32] & PRES;
        sync2_r <= sync1_r;
      end
    end

    assign pin_out[b*32 +: 32] = data_r;
    assign pin_oe[b*32 +: 32]  = dir_r & oe_r;
    assign rd_part[b*32 +: 32] = (addr == A_DATA) ? data_r  :
                                 (addr == A_IN)   ? sync2_r :
                                 (addr == A_DIR)  ? dir_r   :
                                 (addr == A_OE)   ? oe_r    : 32'h0;
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_data = rd_data | rd_part[b*32 +: 32];
  end
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W = 12,
  parameter logic [NUM_BANKS*32-1:0] PIN_PRESENT = '1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wr_data,
  input logic [31:0]             rd_data,
  input logic [NUM_BANKS*32-1:0] pin_out,
  input logic [NUM_BANKS*32-1:0] pin_oe,
  input logic [NUM_BANKS*32-1:0] pin_in
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0));

  a_r2_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(64)) |=> pin_out[31:0] == ($past(wr_data) & PIN_PRESENT[31:0]));

  a_r3_masked_low_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |=>
      (((pin_out[15:0] ^ $past(pin_out[15:0])) & $past(wr_data[31:16])) == 16'h0) &&
      (pin_out[31:16] == $past(pin_out[31:16])));

  a_r4_masked_high_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=>
      ((pin_out[31:16] & ~$past(wr_data[31:16])) == ($past(wr_data[15:0]) & ~$past(wr_data[31:16]))) &&
      (pin_out[15:0] == $past(pin_out[15:0])));

  a_r5_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(516) && wr_data == 32'h0) |=> pin_oe[31:0] == 32'h0);

  a_r6_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && addr == ADDR_W'(96)) |-> rd_data == ($past(pin_in[31:0], 2) & PIN_PRESENT[31:0]));

  a_r7_absent_pins: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_out & ~PIN_PRESENT) == '0) && ((pin_oe & ~PIN_PRESENT) == '0));

  a_r8_maskport_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < ADDR_W'(64)) |-> rd_data == 32'h0);
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .PIN_PRESENT(PIN_PRESENT)
) u_chk (.*);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
  localparam int NB = 4;
  localparam logic [NB*32-1:0] PRES =
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h003F_FFFF, 32'hFFFF_FFFF};

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [NB*32-1:0] pin_out, pin_oe, pin_in = '0;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_data [NB];
  logic [31:0] m_dir [NB];
  logic [31:0] m_oe [NB];

  always #10 clk = ~clk;

  gpio_bank_ctrl dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in));

  function automatic logic [31:0] pres(int b);
    return PRES[b*32 +: 32];
  endfunction

  function automatic logic [15:0] mmerge(logic [15:0] old, logic [31:0] w);
    return (old & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1 chk(rd_data, exp, req);
  endtask

  task automatic bank_chk(int b, string req);
    rd_chk(12'(64 + 4*b), m_data[b], req);
    rd_chk(12'(516 + 64*b), m_dir[b], req);
    rd_chk(12'(520 + 64*b), m_oe[b], req);
    chk(pin_out[b*32 +: 32], m_data[b], req);
    chk(pin_oe[b*32 +: 32], m_dir[b] & m_oe[b], req);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < NB; b++) begin m_data[b] = 0; m_dir[b] = 0; m_oe[b] = 0; end
    repeat (3) @(negedge clk);
    #1 chk(pin_out[31:0], 0, "R1"); chk(pin_oe[31:0], 0, "R1");
    rst_n = 1;
    for (int b = 0; b < NB; b++) bank_chk(b, "R1");

    // R2 full write, R7 absent bits in bank 1
    wr(12'h040, 32'hA5A5_3C3C); m_data[0] = 32'hA5A5_3C3C; bank_chk(0, "R2");
    wr(12'h044, 32'hFFFF_FFFF); m_data[1] = 32'h003F_FFFF; bank_chk(1, "R7");
    wr(12'h244, 32'hFFFF_FFFF); m_dir[1] = 32'h003F_FFFF;
    wr(12'h248, 32'hFFFF_FFFF); m_oe[1] = 32'h003F_FFFF; bank_chk(1, "R7");
    wr(12'h00C, 32'h0000_FFFF); m_data[1][31:16] = 16'h003F; bank_chk(1, "R7");

    // R3/R4 directed masks: empty, full
    wr(12'h000, 32'hFFFF_0000); bank_chk(0, "R3");
    wr(12'h000, 32'h0000_1234); m_data[0][15:0] = 16'h1234; bank_chk(0, "R3");
    wr(12'h004, 32'h00FF_BEEF); m_data[0][31:16] = mmerge(m_data[0][31:16], 32'h00FF_BEEF); bank_chk(0, "R4");

    // R5 direction / enable combinations on bank 3
    wr(12'h2C8, 32'hFFFF_FFFF); m_oe[3] = '1; bank_chk(3, "R5");
    wr(12'h2C4, 32'h0000_FFFF); m_dir[3] = 32'h0000_FFFF; bank_chk(3, "R5");
    wr(12'h2C8, 32'h00FF_00FF); m_oe[3] = 32'h00FF_00FF; bank_chk(3, "R5");

    // R8 mask-port and unmapped reads
    rd_chk(12'h000, 0, "R8"); rd_chk(12'h01C, 0, "R8");
    rd_chk(12'h300, 0, "R8"); rd_chk(12'h200, 0, "R8");

    // R6 two-edge lag on bank 2 and bank 1
    @(negedge clk); addr = 12'h068; pin_in = {32'h0, 32'hCAFE_F00D, 32'hFFFF_FFFF, 32'h0};
    @(posedge clk); #1 chk(rd_data, 0, "R6");
    @(posedge clk); #1 chk(rd_data, 32'hCAFE_F00D, "R6");
    rd_chk(12'h064, 32'h003F_FFFF, "R6");

    for (int i = 0; i < 300; i++) begin
      int b, op;
      logic [31:0] d;
      b = $urandom_range(NB - 1); op = $urandom_range(4); d = $urandom;
      case (op)
        0: begin wr(12'(64 + 4*b), d); m_data[b] = d & pres(b); bank_chk(b, "R2"); end
        1: begin wr(12'(8*b), d); m_data[b][15:0] = mmerge(m_data[b][15:0], d);
                 m_data[b] &= pres(b); bank_chk(b, "R3"); end
        2: begin wr(12'(8*b + 4), d); m_data[b][31:16] = mmerge(m_data[b][31:16], d);
                 m_data[b] &= pres(b); bank_chk(b, "R4"); end
        3: begin wr(12'(516 + 64*b), d); m_dir[b] = d & pres(b); bank_chk(b, "R5"); end
        default: begin wr(12'(520 + 64*b), d); m_oe[b] = d & pres(b); bank_chk(b, "R5"); end
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule